// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers event pulses from eight sources and drives one active-low interrupt request line, `irq_n`, toward a host processor. The sources fall into groups: bus transceiver, voltage monitor, low-side driver, high-side driver, wake-up and forced wake-up. Each source has a sticky flag that is set on a rising edge of its event input. A 4-bit write-only mask enables or disables the request for the maskable groups. A masked flag still latches and is still reported. Some voltage events and both wake-up sources ignore the mask.

The host reaches the block through a small access port. A write loads the mask. A read returns a 4-bit code naming the highest-priority pending source and acknowledges that source, clearing its flag. Every access, write or read, produces one response beat that carries the source code as it stood when the access was accepted.

An acknowledge can leave other enabled sources still pending. In that case the request line is released high for a fixed interval, 10 µs by default, and is then driven low again, so that an edge-triggered host sees a fresh request.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1, all flags are clear and the mask is 0. A read issued first therefore returns code 0.
- R2: A flag sets on a 0-to-1 transition of its `evt_in` bit. An input held high after its flag has been acknowledged does not set the flag again.
- R3: Mask bit 0 enables the bus source (`evt_in[0]`), bit 2 the low-side source (`evt_in[4]`) and bit 3 the high-side source (`evt_in[5]`), with 1 meaning enabled. A masked pending flag leaves `irq_n` high but is still reported by a read.
- R4: Under-voltage (`evt_in[2]`), regulator over-temperature warning (`evt_in[3]`), wake-up (`evt_in[6]`) and forced wake-up (`evt_in[7]`) pull `irq_n` low whatever the mask holds.
- R5: Over-voltage (`evt_in[1]`) is the only voltage source gated by a mask bit, namely mask bit 1.
- R6: The read code is 7 for forced wake-up, 6 for wake-up, 5 for high-side, 4 for low-side, 3 for under-voltage or over-temperature warning, 2 for over-voltage, 1 for bus, and 0 when nothing is pending. A read always reports the highest pending code.
- R7: An access accepted on a clock edge produces `rsp_valid`=1 for the following cycle, with `rsp_code` set to the code as it was before that edge. A read clears every flag that maps to the reported code.
- R8: A write (`acc_write`=1) loads `acc_wdata` into the mask, returns the current code, and clears no flag.
- R9: When a read acknowledges a nonzero code and an enabled flag is still pending, `irq_n` is held high for GAP_CYC cycles (CLK_FREQ_HZ/1e6 × RELEASE_US, 100 by default) and then goes low.
- R10: When a read acknowledges a nonzero code and no enabled flag remains, `irq_n` goes high and stays high until a new enabled flag sets.
- R11: Under-voltage and over-temperature warning share code 3, and one read of that code clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Host access strobe, one cycle per access |
| acc_write | input | 1 | 1 = mask write, 0 = source read with acknowledge |
| acc_wdata | input | 4 | Mask value for a write |
| rsp_valid | output | 1 | Response beat for the previous access |
| rsp_code | output | 4 | Source code returned by the access |
| evt_in | input | 8 | Event inputs, one bit per source |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that `evt_in` is synchronous to `clk` and that the host issues accesses as single-cycle strobes. They also assume the host has no back-pressure, so every response beat is taken in the cycle it appears. The bench drives events and accesses only on the falling clock edge. It uses each access strobe for exactly one cycle and spaces accesses at least two cycles apart, so every response beat reaches the scoreboard monitor before the next access. Event pulses last one cycle, apart from one deliberately held level that checks edge-only latching.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NSRC   = 8;
  localparam int CODE_W = 4;
  localparam int MASK_W = 4;

  // source index -> reported code (larger code = higher priority)
  function automatic logic [CODE_W-1:0] src_code(input int idx);
    case (idx)
      0:       return 4'd1;
      1:       return 4'd2;
      2, 3:    return 4'd3;
      4:       return 4'd4;
      5:       return 4'd5;
      6:       return 4'd6;
      7:       return 4'd7;
      default: return 4'd0;
    endcase
  endfunction

  // request enable of one source under a given mask
  function automatic logic src_enabled(input logic [MASK_W-1:0] m, input int idx);
    case (idx)
      0:       return m[0];
      1:       return m[1];
      4:       return m[2];
      5:       return m[3];
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import prio_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_in,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  logic [N-1:0] evt_prev;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        evt_prev[i] <= 1'b0;
        flags[i]    <= 1'b0;
      end else begin
        evt_prev[i] <= evt_in[i];
        // a fresh edge wins over a same-cycle clear
        flags[i]    <= (flags[i] & ~clr_mask[i]) | (evt_in[i] & ~evt_prev[i]);
      end
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import prio_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]      flags,
  output logic [CODE_W-1:0] code,
  output logic [N-1:0]      same_code
);
  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (flags[i] && (src_code(i) > code)) code = src_code(i);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_sel
    assign same_code[i] = (code != '0) && (src_code(i) == code);
  end
endmodule

// File: rtl/irq_gap_timer.sv
module irq_gap_timer #(
  parameter int GAP_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(GAP_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (start)        cnt <= LOAD;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 10_000_000,
  parameter int RELEASE_US  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [MASK_W-1:0] acc_wdata,
  output logic              rsp_valid,
  output logic [CODE_W-1:0] rsp_code,
  input  logic [NSRC-1:0]   evt_in,
  output logic              irq_n
);
  localparam int GAP_CYC = (CLK_FREQ_HZ / 1_000_000) * RELEASE_US;

  logic [MASK_W-1:0] mask_q;
  logic [NSRC-1:0]   flags, same_code, clr_mask, en_vec, enabled;
  logic [CODE_W-1:0] cur_code;
  logic              ack, gap_start, gap_active;

  for (genvar i = 0; i < NSRC; i++) begin : g_en
    assign en_vec[i] = src_enabled(mask_q, i);
  end

  irq_flag_bank #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .clr_mask(clr_mask), .flags(flags)
  );

  irq_prio_enc #(.N(NSRC)) u_enc (
    .flags(flags), .code(cur_code), .same_code(same_code)
  );

  irq_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .start(gap_start), .active(gap_active)
  );

  assign ack       = acc_valid & ~acc_write;
  assign clr_mask  = ack ? same_code : '0;
  assign enabled   = flags & en_vec;
  assign gap_start = ack && (cur_code != '0) && (|(enabled & ~clr_mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_code  <= '0;
    end else begin
      rsp_valid <= acc_valid;
      if (acc_valid) rsp_code <= cur_code;
      if (acc_valid && acc_write) mask_q <= acc_wdata;
    end
  end

  assign irq_n = ~(|enabled) | gap_active;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              rsp_valid,
  input logic [CODE_W-1:0] rsp_code,
  input logic [CODE_W-1:0] cur_code,
  input logic [NSRC-1:0]   flags,
  input logic [MASK_W-1:0] mask_q,
  input logic              irq_n
);
  // R7
  rsp_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);

  // R7
  rsp_code_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_code == $past(cur_code));

  // R10
  ack_releases_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && cur_code != '0) |=> irq_n);

  // R3
  masked_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0 && (flags & 8'b1100_1100) == '0) |-> irq_n);

  // R8
  write_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |=> ((flags | $past(flags)) == flags));

  // R6
  zero_code_means_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_code == '0) |-> (flags == '0));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .rsp_valid(rsp_valid), .rsp_code(rsp_code), .cur_code(cur_code),
  .flags(flags), .mask_q(mask_q), .irq_n(irq_n)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_write = 1'b0;
  logic [3:0] acc_wdata = '0;
  logic       rsp_valid;
  logic [3:0] rsp_code;
  logic [7:0] evt_in = '0;
  logic       irq_n;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  string tag_q[$];

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_wdata(acc_wdata), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .evt_in(evt_in), .irq_n(irq_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_irq(input logic exp, input string req);
    n_cmp++;
    if (irq_n !== exp) begin
      n_bad++;
      $display("FAIL %s irq_n actual=%0b expected=%0b", req, irq_n, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] bits);
    evt_in = evt_in | bits;
    @(negedge clk);
    evt_in = evt_in & ~bits;
    @(negedge clk);
  endtask

  task automatic rd(input int exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    acc_valid = 1'b1; acc_write = 1'b0;
    @(negedge clk);
    acc_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] m, input int exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    acc_valid = 1'b1; acc_write = 1'b1; acc_wdata = m;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R7 unexpected response actual=%0d expected=none", rsp_code);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_code !== 4'(e)) begin
          n_bad++;
          $display("FAIL %s rsp_code actual=%0d expected=%0d", t, rsp_code, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check_irq(1'b1, "R1");
    rd(0, "R1");

    // masked high-side: line stays high, flag still reported
    pulse(8'h20);
    check_irq(1'b1, "R3");
    rd(5, "R3");
    rd(0, "R7");

    // under-voltage ignores the mask
    pulse(8'h04);
    check_irq(1'b0, "R4");
    rd(3, "R4");
    check_irq(1'b1, "R10");

    // wake-up ignores the mask
    pulse(8'h40);
    check_irq(1'b0, "R4");
    rd(6, "R4");

    // over-voltage gated only by mask bit 1
    pulse(8'h02);
    check_irq(1'b1, "R5");
    wr(4'b0010, 2, "R8");
    check_irq(1'b0, "R5");
    rd(2, "R5");

    // shared code 3 clears both flags
    pulse(8'h0C);
    rd(3, "R11");
    rd(0, "R11");
    check_irq(1'b1, "R11");

    // release gap with another source pending
    wr(4'b1111, 0, "R8");
    pulse(8'h21);
    check_irq(1'b0, "R3");
    rd(5, "R9");
    idle(GAP - 5);
    check_irq(1'b1, "R9");
    idle(6);
    check_irq(1'b0, "R9");
    rd(1, "R10");
    idle(GAP + 5);
    check_irq(1'b1, "R10");

    // priority ordering with many pending
    pulse(8'hD3);
    wr(4'b1111, 7, "R8");
    rd(7, "R6");
    rd(6, "R6");
    rd(4, "R6");
    rd(2, "R6");
    rd(1, "R6");
    rd(0, "R6");

    // held level sets once only
    evt_in[4] = 1'b1;
    idle(2);
    rd(4, "R2");
    idle(3);
    rd(0, "R2");
    check_irq(1'b1, "R2");
    evt_in[4] = 1'b0;
    idle(GAP + 5);

    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R7 missing responses actual=%0d expected=0", exp_q.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule